// File: doc/BRIEF.md
# E3 receive alarm interrupt controller

This block sits behind an E3 receive framer and turns its per-frame indications into three alarm conditions: out-of-frame, loss-of-frame and alarm indication signal (AIS). The framer supplies a frame-boundary strobe at the end of every frame. A framing-bit error flag and an in-frame indication come with it. The block also takes the received bit stream with a bit-valid strobe, and a one-pulse-per-millisecond timebase.

Out-of-frame is declared after a run of framing-bit errors. Loss-of-frame follows only if alignment is not regained within a software-selected 1 ms or 3 ms window. AIS is judged from the number of zero bits seen over a pair of frames.

Each condition raises a change-of-state interrupt both when it is declared and when it clears, provided its enable bit is set. A small register port gives software the live flags, the window select, the enables and a sticky, clear-on-read interrupt status. An active-low interrupt line is pulled low while any enabled status bit is pending.

Top module: `e3_rx_alarm_irq`

## Requirements
- R1: Out-of-frame is declared on the boundary strobe of the 4th consecutive frame whose framing-bit error flag is 1. A strobe with the flag at 0 restarts the run. The flag appears in register 0 bit 1 one cycle after that strobe.
- R2: While out-of-frame is held and loss-of-frame is not, loss-of-frame is declared on the 1st timebase tick when register 0 bit 7 is 0, or on the 3rd tick when that bit is 1. Ticks are counted from entry into out-of-frame. The flag appears in register 0 bit 2.
- R3: Loss-of-frame is only ever set while out-of-frame is set. If alignment is regained before the window ends, the tick count is discarded, and a later out-of-frame entry starts counting from zero.
- R4: A 0-to-1 transition of the in-frame input clears both out-of-frame and loss-of-frame on the same clock edge.
- R5: At the close of each two-frame window, AIS (register 0 bit 0) is set if 7 or fewer valid zero bits arrived in the window and is cleared if more arrived. A window closes on every second boundary strobe counted from reset, and it covers the bits received since the previous close.
- R6: AIS changes only at a window-closing strobe and holds its value across the intervening strobe.
- R7: Register 0 reads as {window select, 0000, loss-of-frame, out-of-frame, AIS}. Only bit 7 is writable, and writes to bits 6:0 are ignored. Register 1 bits 2:0 are the enables for AIS, out-of-frame and loss-of-frame change interrupts, in that bit order, and reset to 0.
- R8: Register 2 bits 2:0, in the same bit order as register 1, become 1 after either a declare or a clear of the matching condition, but only when that condition's enable is 1. A disabled condition leaves its bit at 0.
- R9: irq_n is 0 exactly while some register 2 bit is 1 and its enable in register 1 is also 1.
- R10: A read of register 2 returns the value held before the read and clears it. A change event in the same cycle as the read is kept and is visible on the next read.
- R11: After reset all flags, enables, status bits and the window select are 0 and irq_n is 1. Read data is registered and appears the cycle after reg_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle strobe at the end of each received frame |
| fbit_err | input | 1 | Framing-bit error for the frame ending at this strobe |
| in_frame | input | 1 | Framer alignment indication; a rising edge means alignment regained |
| rx_bit | input | 1 | Received data bit |
| rx_bit_vld | input | 1 | rx_bit carries a valid bit this cycle |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| reg_addr | input | 2 | Register select: 0 config/flags, 1 enables, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker watches every cycle for the following:
- loss-of-frame never being set without out-of-frame;
- out-of-frame rising only after an errored strobe;
- loss-of-frame rising only on a tick;
- loss-of-frame clearing only together with out-of-frame;
- AIS moving only on a boundary strobe;
- a status bit setting after every enabled change event, and a disabled bit staying clear;
- irq_n never falling without a pending status.

Only the bench's scenarios can show the counting itself: the exact error run length, the 1 versus 3 tick window and its restart, and the zero thresholds on both sides of 7. They also show the two-frame pairing, register masking, and a change event that lands in the same cycle as a status read.

// File: rtl/e3_alarm_pkg.sv
package e3_alarm_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;
  localparam logic [REG_AW-1:0] ADDR_CFG  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_EN   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;
  localparam int BIT_AIS = 0;
  localparam int BIT_OOF = 1;
  localparam int BIT_LOF = 2;
  localparam int BIT_WIN = 7;
  localparam int NUM_COND = 3;

  // persistence window length in ticks for the chosen select
  function automatic int lof_window_ticks(logic long_sel, int short_ms, int long_ms);
    return long_sel ? long_ms : short_ms;
  endfunction

  // AIS verdict over a closed two-frame window
  function automatic logic ais_verdict(int zeros, int max_zeros);
    return zeros <= max_zeros;
  endfunction

  // next value of the consecutive errored-frame run
  function automatic int err_run_next(int run, logic err);
    return err ? run + 1 : 0;
  endfunction
endpackage

// File: rtl/e3_oof_lof_mon.sv
module e3_oof_lof_mon
  import e3_alarm_pkg::*;
#(
  parameter int OOF_FRAMES   = 4,
  parameter int LOF_SHORT_MS = 1,
  parameter int LOF_LONG_MS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic fbit_err,
  input  logic in_frame,
  input  logic tick_1ms,
  input  logic win_long,
  output logic oof,
  output logic lof,
  output logic oof_set,
  output logic oof_clr,
  output logic lof_set,
  output logic lof_clr
);
  localparam int EW = $clog2(OOF_FRAMES + 1);
  localparam int TW = $clog2(LOF_LONG_MS + 1);

  logic [EW-1:0] err_run;
  logic [TW-1:0] tick_cnt;
  logic          in_frame_q;
  logic          regain;
  logic          win_hit;

  assign regain  = in_frame && !in_frame_q;
  assign oof_set = !oof && frame_sync && fbit_err && (int'(err_run) == OOF_FRAMES - 1);
  assign oof_clr = oof && regain;
  assign win_hit = (int'(tick_cnt) + 1) >= lof_window_ticks(win_long, LOF_SHORT_MS, LOF_LONG_MS);
  assign lof_set = oof && !lof && !regain && tick_1ms && win_hit;
  assign lof_clr = lof && oof_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_run    <= '0;
      tick_cnt   <= '0;
      in_frame_q <= 1'b0;
      oof        <= 1'b0;
      lof        <= 1'b0;
    end else begin
      in_frame_q <= in_frame;
      if (oof || oof_set)
        err_run <= '0;
      else if (frame_sync)
        err_run <= EW'(err_run_next(int'(err_run), fbit_err));
      if (!oof || lof || regain)
        tick_cnt <= '0;
      else if (tick_1ms)
        tick_cnt <= tick_cnt + TW'(1);
      if (oof_set)      oof <= 1'b1;
      else if (oof_clr) oof <= 1'b0;
      if (lof_set)      lof <= 1'b1;
      else if (lof_clr) lof <= 1'b0;
    end
  end
endmodule

// File: rtl/e3_ais_mon.sv
module e3_ais_mon
  import e3_alarm_pkg::*;
#(
  parameter int AIS_MAX_ZEROS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_sync,
  input  logic rx_bit,
  input  logic rx_bit_vld,
  output logic ais,
  output logic ais_set,
  output logic ais_clr
);
  localparam int ZW = $clog2(AIS_MAX_ZEROS + 2);
  localparam logic [ZW-1:0] ZSAT = ZW'(AIS_MAX_ZEROS + 1);

  logic [ZW-1:0] zcnt;
  logic [ZW-1:0] ztot;
  logic          pair_odd;
  logic          win_close;
  logic          verdict;
  logic          zero_in;

  assign zero_in   = rx_bit_vld && !rx_bit;
  assign ztot      = (zcnt == ZSAT) ? ZSAT : zcnt + ZW'(zero_in);
  assign win_close = frame_sync && pair_odd;
  assign verdict   = ais_verdict(int'(ztot), AIS_MAX_ZEROS);
  assign ais_set   = win_close && !ais && verdict;
  assign ais_clr   = win_close && ais && !verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt     <= '0;
      pair_odd <= 1'b0;
      ais      <= 1'b0;
    end else begin
      if (frame_sync) pair_odd <= !pair_odd;
      zcnt <= win_close ? '0 : ztot;
      if (ais_set)      ais <= 1'b1;
      else if (ais_clr) ais <= 1'b0;
    end
  end
endmodule

// File: rtl/e3_alarm_regs.sv
module e3_alarm_regs
  import e3_alarm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic                reg_wr,
  input  logic [REG_DW-1:0]   reg_wdata,
  input  logic                reg_rd,
  input  logic [NUM_COND-1:0] flags,
  input  logic [NUM_COND-1:0] chg,
  output logic [REG_DW-1:0]   reg_rdata,
  output logic                irq_n,
  output logic                win_long,
  output logic [NUM_COND-1:0] irq_en,
  output logic [NUM_COND-1:0] irq_stat
);
  logic [REG_DW-1:0]   rd_mux;
  logic [NUM_COND-1:0] rd_clr;
  logic                unused_wbits;

  assign unused_wbits = ^reg_wdata[BIT_WIN-1:NUM_COND];
  assign rd_clr = (reg_rd && reg_addr == ADDR_STAT) ? '1 : '0;
  assign irq_n  = ~|(irq_stat & irq_en);

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_CFG: begin
        rd_mux[BIT_WIN]        = win_long;
        rd_mux[NUM_COND-1:0]   = flags;
      end
      ADDR_EN:   rd_mux[NUM_COND-1:0] = irq_en;
      ADDR_STAT: rd_mux[NUM_COND-1:0] = irq_stat;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_long  <= 1'b0;
      irq_en    <= '0;
      irq_stat  <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CFG) win_long <= reg_wdata[BIT_WIN];
      if (reg_wr && reg_addr == ADDR_EN)  irq_en   <= reg_wdata[NUM_COND-1:0];
      if (reg_rd) reg_rdata <= rd_mux;
      // new events win over the read clear
      irq_stat <= (irq_stat & ~rd_clr) | (chg & irq_en);
    end
  end
endmodule

// File: rtl/e3_rx_alarm_irq.sv
module e3_rx_alarm_irq
  import e3_alarm_pkg::*;
#(
  parameter int OOF_FRAMES    = 4,
  parameter int LOF_SHORT_MS  = 1,
  parameter int LOF_LONG_MS   = 3,
  parameter int AIS_MAX_ZEROS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_sync,
  input  logic        fbit_err,
  input  logic        in_frame,
  input  logic        rx_bit,
  input  logic        rx_bit_vld,
  input  logic        tick_1ms,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_rd,
  output logic [7:0]  reg_rdata,
  output logic        irq_n
);
  logic oof, lof, ais;
  logic oof_set, oof_clr, lof_set, lof_clr, ais_set, ais_clr;
  logic win_long;
  logic [NUM_COND-1:0] flags, chg, irq_en, irq_stat;

  assign flags = {lof, oof, ais};
  assign chg   = {lof_set | lof_clr, oof_set | oof_clr, ais_set | ais_clr};

  e3_oof_lof_mon #(
    .OOF_FRAMES(OOF_FRAMES), .LOF_SHORT_MS(LOF_SHORT_MS), .LOF_LONG_MS(LOF_LONG_MS)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .fbit_err(fbit_err),
    .in_frame(in_frame), .tick_1ms(tick_1ms), .win_long(win_long),
    .oof(oof), .lof(lof), .oof_set(oof_set), .oof_clr(oof_clr),
    .lof_set(lof_set), .lof_clr(lof_clr)
  );

  e3_ais_mon #(.AIS_MAX_ZEROS(AIS_MAX_ZEROS)) u_ais (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .rx_bit(rx_bit),
    .rx_bit_vld(rx_bit_vld), .ais(ais), .ais_set(ais_set), .ais_clr(ais_clr)
  );

  e3_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .flags(flags), .chg(chg),
    .reg_rdata(reg_rdata), .irq_n(irq_n), .win_long(win_long),
    .irq_en(irq_en), .irq_stat(irq_stat)
  );
endmodule

// File: rtl/e3_rx_alarm_irq_chk.sv
module e3_rx_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_sync,
  input logic       fbit_err,
  input logic       tick_1ms,
  input logic       oof,
  input logic       lof,
  input logic       ais,
  input logic [2:0] chg,
  input logic [2:0] irq_en,
  input logic [2:0] irq_stat,
  input logic       irq_n
);
  AST_LOF_WITHIN_OOF: assert property (@(posedge clk) disable iff (!rst_n) lof |-> oof); // R3
  AST_OOF_RISE_ERRSTROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> $past(frame_sync && fbit_err)); // R1
  AST_LOF_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof) |-> $past(tick_1ms)); // R2
  AST_LOF_FALL_WITH_OOF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof) |-> $fell(oof)); // R4
  AST_AIS_MOVES_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais) |-> $past(frame_sync)); // R6
  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (irq_stat != 3'b000)); // R9

  for (genvar i = 0; i < 3; i++) begin : g_stat
    AST_STAT_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[i] && chg[i]) |=> irq_stat[i]); // R8
    AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en[i] && !irq_stat[i]) |=> !irq_stat[i]); // R8
  end
endmodule

bind e3_rx_alarm_irq e3_rx_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .fbit_err(fbit_err),
  .tick_1ms(tick_1ms), .oof(oof), .lof(lof), .ais(ais), .chg(chg),
  .irq_en(irq_en), .irq_stat(irq_stat), .irq_n(irq_n)
);

// File: tb/e3_rx_alarm_irq_bench.sv
`timescale 1ns/1ps
module e3_rx_alarm_irq_bench;
  localparam int FRAME_BITS = 16;
  localparam int N_AIS = 8;
  // {zeros in first frame, zeros in second frame, expected AIS}
  localparam logic [16:0] AIS_VEC [N_AIS] = '{
    {8'd3, 8'd4, 1'b1}, {8'd4, 8'd4, 1'b0}, {8'd7, 8'd0, 1'b1}, {8'd0, 8'd8, 1'b0},
    {8'd0, 8'd7, 1'b1}, {8'd16, 8'd16, 1'b0}, {8'd2, 8'd2, 1'b1}, {8'd8, 8'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0, fbit_err = 1'b0, in_frame = 1'b1;
  logic rx_bit = 1'b1, rx_bit_vld = 1'b0, tick_1ms = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq_n;
  int total = 0, bad = 0;
  logic [7:0] rv;
  logic prev_ais;

  always #2 clk = ~clk;

  e3_rx_alarm_irq u_e3_rx_alarm_irq (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .fbit_err(fbit_err),
    .in_frame(in_frame), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld), .tick_1ms(tick_1ms),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic strobe(input logic err);
    @(negedge clk); frame_sync = 1'b1; fbit_err = err;
    @(negedge clk); frame_sync = 1'b0; fbit_err = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1ms = 1'b1;
    @(negedge clk); tick_1ms = 1'b0;
  endtask

  task automatic set_align(input logic v);
    @(negedge clk); in_frame = v;
    @(negedge clk);
  endtask

  task automatic send_frame(input int zeros);
    for (int i = 0; i < FRAME_BITS; i++) begin
      @(negedge clk); rx_bit_vld = 1'b1; rx_bit = (i < zeros) ? 1'b0 : 1'b1;
    end
    @(negedge clk); rx_bit_vld = 1'b0; rx_bit = 1'b1;
    strobe(1'b0);
  endtask

  task automatic oof_enter();
    for (int i = 0; i < 4; i++) strobe(1'b1);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check("R11 irq_n", {7'd0, irq_n}, 8'h01);
    rd(2'd0, rv); check("R11 reg0", rv, 8'h00);
    rd(2'd1, rv); check("R11 reg1", rv, 8'h00);
    rd(2'd2, rv); check("R11 reg2", rv, 8'h00);
    // R7 only bit 7 of reg0 writable
    wr(2'd0, 8'hFF); rd(2'd0, rv); check("R7 reg0 ro bits", rv, 8'h80);
    wr(2'd0, 8'h00); rd(2'd0, rv); check("R7 reg0 sel clear", rv, 8'h00);
    wr(2'd1, 8'hF8); rd(2'd1, rv); check("R7 reg1 upper ignored", rv, 8'h00);

    // R5 and R6 table of two-frame windows
    prev_ais = 1'b0;
    for (int k = 0; k < N_AIS; k++) begin
      send_frame(int'(AIS_VEC[k][16:9]));
      rd(2'd0, rv); check("R6 ais held mid window", {7'd0, rv[0]}, {7'd0, prev_ais});
      send_frame(int'(AIS_VEC[k][8:1]));
      rd(2'd0, rv); check("R5 ais verdict", {7'd0, rv[0]}, {7'd0, AIS_VEC[k][0]});
      prev_ais = AIS_VEC[k][0];
    end

    // R8 R9 R10 AIS change interrupt
    wr(2'd1, 8'h01);
    send_frame(0); send_frame(0);
    check("R9 irq low on ais", {7'd0, irq_n}, 8'h00);
    wr(2'd1, 8'h00);
    check("R9 irq released when disabled", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h01);
    check("R9 irq back when enabled", {7'd0, irq_n}, 8'h00);
    rd(2'd2, rv); check("R10 read returns status", rv, 8'h01);
    rd(2'd2, rv); check("R10 status cleared", rv, 8'h00);
    check("R9 irq high after clear", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'h00);
    send_frame(9); send_frame(0);
    rd(2'd0, rv); check("R5 ais cleared", {7'd0, rv[0]}, 8'h00);
    rd(2'd2, rv); check("R8 disabled ais no status", rv, 8'h00);

    // R1 run of errors, clean frame restarts
    wr(2'd1, 8'h06);
    set_align(1'b0);
    strobe(1'b1); strobe(1'b1); strobe(1'b1); strobe(1'b0);
    strobe(1'b1); strobe(1'b1); strobe(1'b1);
    rd(2'd0, rv); check("R1 no oof after broken run", rv & 8'h06, 8'h00);
    strobe(1'b1);
    rd(2'd0, rv); check("R1 oof after 4 errors", rv & 8'h06, 8'h02);
    rd(2'd2, rv); check("R8 oof declare status", rv, 8'h02);
    // R2 short window
    tick();
    rd(2'd0, rv); check("R2 lof after 1 tick", rv & 8'h06, 8'h06);
    check("R9 irq low on lof", {7'd0, irq_n}, 8'h00);
    rd(2'd2, rv); check("R8 lof declare status", rv, 8'h04);
    // R4 regain clears both
    set_align(1'b1);
    rd(2'd0, rv); check("R4 flags cleared", rv & 8'h06, 8'h00);
    rd(2'd2, rv); check("R8 clear events status", rv, 8'h06);

    // R2 long window
    wr(2'd0, 8'h80);
    set_align(1'b0); oof_enter();
    tick(); tick();
    rd(2'd0, rv); check("R2 no lof after 2 ticks", rv & 8'h86, 8'h82);
    tick();
    rd(2'd0, rv); check("R2 lof after 3 ticks", rv & 8'h86, 8'h86);
    set_align(1'b1);

    // R3 abort and restart of window
    set_align(1'b0); oof_enter();
    tick(); tick();
    set_align(1'b1);
    rd(2'd0, rv); check("R3 aborted no lof", rv & 8'h06, 8'h00);
    set_align(1'b0); oof_enter();
    tick();
    rd(2'd0, rv); check("R3 count restarted", rv & 8'h06, 8'h02);
    tick(); tick();
    rd(2'd0, rv); check("R3 lof after full window", rv & 8'h06, 8'h06);
    set_align(1'b1);

    // R10 event in same cycle as status read
    wr(2'd1, 8'h02);
    rd(2'd2, rv);
    set_align(1'b0);
    strobe(1'b1); strobe(1'b1); strobe(1'b1);
    @(negedge clk); frame_sync = 1'b1; fbit_err = 1'b1; reg_addr = 2'd2; reg_rd = 1'b1;
    @(negedge clk); frame_sync = 1'b0; fbit_err = 1'b0; reg_rd = 1'b0; rv = reg_rdata;
    check("R10 read sees pre-event value", rv, 8'h00);
    rd(2'd2, rv); check("R10 same-cycle event kept", rv, 8'h02);
    set_align(1'b1);
    rd(2'd0, rv); check("R4 oof cleared at end", rv & 8'h06, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule